// File: doc/BRIEF.md
# Shared Tone Output Port

A four-pin output port whose lowest pin can serve either as an ordinary latched output or as the output of a square-wave tone generator. Software-style writes arrive on two register-style strobes. One loads the data latch for all pins. The other loads a control word. Control bit 3 selects the function of pin 0, and control bits 2:0 select one of eight tone frequencies. Each frequency is made by dividing the system clock. The remaining pins are always plain outputs driven from the latch.

Every pin stays high-impedance from reset until the first data write. Every pin also goes high-impedance while the clock-stop input is high. During clock-stop the port holds its state and ignores writes. When clock-stop ends, the earlier drive state returns and the tone divider starts again from zero. The divide ratio is computed from a base parameter: the half period in clocks is `DIV_BASE << code`.

Top module: `tone_port`

## Requirements
- R1: From reset until the first accepted data write, every bit of `pin_oe` is 0. This holds even if control writes occur in that time.
- R2: A data write (`data_we` high on a rising edge, `clk_stop` low) loads the latch. From the next cycle every `pin_oe` bit is 1 and, in output mode, `pin_out` equals the written value.
- R3: Control bit 3 picks the function of pin 0. With bit 3 = 1, `pin_out[0]` carries the tone. With bit 3 = 0, `pin_out[0]` carries latch bit 0.
- R4: The tone is a 50% duty square wave with a half period of `DIV_BASE << code` clocks, where code is control bits 2:0. After a control write that changes the code, the tone is low for one half period, counted from the cycle after the write, and then alternates.
- R5: In tone mode a data write updates latch bit 0 but does not change `pin_out[0]`. A later control write with bit 3 = 0 makes `pin_out[0]` show that latch bit in the very next cycle.
- R6: Pins 1 to 3 always follow the matching latch bits, whatever the mode.
- R7: While `clk_stop` is high, every `pin_oe` bit is 0 in the same cycle. Data and control writes made during that time are ignored.
- R8: After `clk_stop` falls, the enables, latch, mode and code are those in force before entry. The tone divider restarts from zero, so the tone is low for one half period and then toggles.
- R9: A control write that leaves the code unchanged does not restart the tone; its phase continues.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, also the tone divider source |
| rst_n | input | 1 | Active-low asynchronous power-on reset |
| clk_stop | input | 1 | Clock-stop mode: pins released, writes ignored |
| data_we | input | 1 | Data latch write strobe |
| data_wdata | input | NPINS | Data latch write value, bit i for pin i |
| ctrl_we | input | 1 | Control write strobe |
| ctrl_wdata | input | 4 | Control value: bit 3 tone mode, bits 2:0 frequency code |
| pin_out | output | NPINS | Pin drive values |
| pin_oe | output | NPINS | Pin output enables, 1 = driving |

## Verification
The bench builds the port with `NPINS = 4` and `DIV_BASE = 2`. This gives half periods from 2 clocks (code 0) up to 256 clocks (code 7). Both ends of the divide range, and a middle code, can then be checked over full periods, while the largest setting still fits in about a thousand cycles. The short code-0 and code-1 periods let the bench place a data write, a same-code control write and a clock-stop release at chosen phases of the tone, and compare the waveform cycle by cycle.

// File: rtl/tone_port_pkg.sv
package tone_port_pkg;

  localparam int unsigned CODE_W = 3;
  localparam int unsigned CTRL_W = 4;
  localparam int unsigned MODE_BIT = 3;

  typedef enum logic {
    PIN0_LATCH = 1'b0,
    PIN0_TONE  = 1'b1
  } pin0_mode_e;

  typedef struct packed {
    pin0_mode_e        mode;
    logic [CODE_W-1:0] code;
  } tone_ctrl_t;

  // Half period of the tone in clock cycles for a given code.
  function automatic int unsigned tone_half_cycles(input int unsigned base,
                                                   input logic [CODE_W-1:0] code);
    return base << code;
  endfunction

  // Counter width able to hold the largest half period.
  function automatic int unsigned tone_cnt_width(input int unsigned base);
    return $clog2(base << ((1 << CODE_W) - 1)) + 1;
  endfunction

endpackage

// File: rtl/tone_ctrl_reg.sv
module tone_ctrl_reg
  import tone_port_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wr_data,
  output tone_ctrl_t        ctrl_q,
  output logic              code_change
);

  logic [CODE_W-1:0] new_code;

  assign new_code    = wr_data[CODE_W-1:0];
  assign code_change = wr_en && (new_code != ctrl_q.code);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q.mode <= PIN0_LATCH;
      ctrl_q.code <= '0;
    end else if (wr_en) begin
      ctrl_q.mode <= pin0_mode_e'(wr_data[MODE_BIT]);
      ctrl_q.code <= new_code;
    end
  end

endmodule

// File: rtl/tone_divider.sv
module tone_divider #(
  parameter int unsigned CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold,
  input  logic             restart,
  input  logic [CNT_W-1:0] half_period,
  output logic             tone,
  output logic             wrap
);

  logic [CNT_W-1:0] cnt_q;

  assign wrap = !hold && !restart && (cnt_q == half_period - CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      tone  <= 1'b0;
    end else if (hold || restart) begin
      cnt_q <= '0;
      tone  <= 1'b0;
    end else if (wrap) begin
      cnt_q <= '0;
      tone  <= ~tone;
    end else begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

endmodule

// File: rtl/pin_drive.sv
module pin_drive #(
  parameter int unsigned NPINS = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [NPINS-1:0] wr_data,
  input  logic             stop,
  input  logic             tone_sel,
  input  logic             tone,
  output logic [NPINS-1:0] latch_q,
  output logic             armed_q,
  output logic [NPINS-1:0] pin_out,
  output logic [NPINS-1:0] pin_oe
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= '0;
      armed_q <= 1'b0;
    end else if (wr_en) begin
      latch_q <= wr_data;
      armed_q <= 1'b1;
    end
  end

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    if (i == 0) begin : g_shared
      assign pin_out[i] = tone_sel ? tone : latch_q[i];
    end else begin : g_plain
      assign pin_out[i] = latch_q[i];
    end
    assign pin_oe[i] = armed_q && !stop;
  end

endmodule

// File: rtl/tone_port.sv
module tone_port
  import tone_port_pkg::*;
#(
  parameter int unsigned NPINS    = 4,
  parameter int unsigned DIV_BASE = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clk_stop,
  input  logic              data_we,
  input  logic [NPINS-1:0]  data_wdata,
  input  logic              ctrl_we,
  input  logic [CTRL_W-1:0] ctrl_wdata,
  output logic [NPINS-1:0]  pin_out,
  output logic [NPINS-1:0]  pin_oe
);

  localparam int unsigned CNT_W = tone_cnt_width(DIV_BASE);

  // Named internal events, also watched by the checker.
  logic             data_wr_ev;
  logic             ctrl_wr_ev;
  logic             restart_ev;
  logic             wrap_ev;
  logic             tone_q;
  logic             tone_sel;
  logic             armed_q;
  logic [NPINS-1:0] latch_q;
  logic [CNT_W-1:0] half_period;
  tone_ctrl_t       ctrl_q;

  assign data_wr_ev = data_we && !clk_stop;
  assign ctrl_wr_ev = ctrl_we && !clk_stop;
  assign tone_sel   = (ctrl_q.mode == PIN0_TONE);
  assign half_period = CNT_W'(tone_half_cycles(DIV_BASE, ctrl_q.code));

  tone_ctrl_reg u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (ctrl_wr_ev),
    .wr_data     (ctrl_wdata),
    .ctrl_q      (ctrl_q),
    .code_change (restart_ev)
  );

  tone_divider #(.CNT_W(CNT_W)) u_div (
    .clk         (clk),
    .rst_n       (rst_n),
    .hold        (clk_stop),
    .restart     (restart_ev),
    .half_period (half_period),
    .tone        (tone_q),
    .wrap        (wrap_ev)
  );

  pin_drive #(.NPINS(NPINS)) u_pins (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (data_wr_ev),
    .wr_data  (data_wdata),
    .stop     (clk_stop),
    .tone_sel (tone_sel),
    .tone     (tone_q),
    .latch_q  (latch_q),
    .armed_q  (armed_q),
    .pin_out  (pin_out),
    .pin_oe   (pin_oe)
  );

endmodule

// File: rtl/tone_port_chk.sv
module tone_port_chk #(
  parameter int unsigned NPINS = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clk_stop,
  input logic             data_we,
  input logic [NPINS-1:0] data_wdata,
  input logic             tone_sel,
  input logic             tone_q,
  input logic             restart_ev,
  input logic             wrap_ev,
  input logic [NPINS-1:0] pin_out,
  input logic [NPINS-1:0] pin_oe
);

  logic seen_wr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_wr_q <= 1'b0;
    else if (data_we && !clk_stop) seen_wr_q <= 1'b1;
  end

  a_r1_hiz_before_write: assert property (@(posedge clk) disable iff (!rst_n)
    !seen_wr_q |-> (pin_oe == '0));

  a_r7_stop_hiz: assert property (@(posedge clk) disable iff (!rst_n)
    clk_stop |-> (pin_oe == '0));

  a_r3_tone_on_pin0: assert property (@(posedge clk) disable iff (!rst_n)
    (tone_sel && seen_wr_q && !clk_stop) |-> (pin_out[0] == tone_q && pin_oe[0]));

  a_r6_upper_follow: assert property (@(posedge clk) disable iff (!rst_n)
    (data_we && !clk_stop) |=> (pin_out[NPINS-1:1] == $past(data_wdata[NPINS-1:1])));

  a_r4_toggle_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (tone_q != $past(tone_q)) |-> ($past(wrap_ev) || $past(restart_ev) || $past(clk_stop)));

  a_r8_stop_clears_tone: assert property (@(posedge clk) disable iff (!rst_n)
    clk_stop |=> !tone_q);

  a_r9_restart_low: assert property (@(posedge clk) disable iff (!rst_n)
    restart_ev |=> !tone_q);

endmodule

bind tone_port tone_port_chk #(.NPINS(NPINS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .clk_stop   (clk_stop),
  .data_we    (data_we),
  .data_wdata (data_wdata),
  .tone_sel   (tone_sel),
  .tone_q     (tone_q),
  .restart_ev (restart_ev),
  .wrap_ev    (wrap_ev),
  .pin_out    (pin_out),
  .pin_oe     (pin_oe)
);

// File: tb/tb_tone_port.sv
`timescale 1ns/1ps
module tb_tone_port;

  localparam int NP   = 4;
  localparam int BASE = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          clk_stop = 1'b0;
  logic          data_we = 1'b0;
  logic [NP-1:0] data_wdata = '0;
  logic          ctrl_we = 1'b0;
  logic [3:0]    ctrl_wdata = '0;
  logic [NP-1:0] pin_out;
  logic [NP-1:0] pin_oe;

  int total = 0;
  int bad   = 0;
  int cycles = 0;
  logic [NP-1:0] exp_latch = '0;

  always #5 clk = ~clk;

  tone_port #(.NPINS(NP), .DIV_BASE(BASE)) dut (
    .clk(clk), .rst_n(rst_n), .clk_stop(clk_stop),
    .data_we(data_we), .data_wdata(data_wdata),
    .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
    .pin_out(pin_out), .pin_oe(pin_oe)
  );

  function automatic int half_of(input int code);
    int h = BASE;
    for (int k = 0; k < code; k++) h = h * 2;
    return h;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Drive a write across one rising edge; returns just after the next negedge.
  task automatic wr_data(input logic [NP-1:0] v);
    @(negedge clk); data_we = 1'b1; data_wdata = v;
    @(negedge clk); data_we = 1'b0; #1;
  endtask

  task automatic wr_ctrl(input logic [3:0] v);
    @(negedge clk); ctrl_we = 1'b1; ctrl_wdata = v;
    @(negedge clk); ctrl_we = 1'b0; #1;
  endtask

  // Caller stands at sample index 'start' (after edge E_start since restart).
  task automatic tone_scan(input int half, input int start, input int n,
                           input bit dwr, input logic [NP-1:0] dval,
                           input bit same_ctrl, input logic [3:0] cval,
                           input string req);
    for (int i = start; i < start + n; i++) begin
      int e = (i / half) % 2;
      chk(pin_out[0] == e[0] && pin_oe[0], req, {pin_oe[0], pin_out[0]}, {1'b1, e[0]});
      if (dwr && i >= start + 2)
        chk(pin_out[NP-1:1] == dval[NP-1:1], "R6", pin_out[NP-1:1], dval[NP-1:1]);
      if (dwr && i == start) begin data_we = 1'b1; data_wdata = dval; end
      if (dwr && i == start + 1) data_we = 1'b0;
      if (same_ctrl && i == start + 2) begin ctrl_we = 1'b1; ctrl_wdata = cval; end
      if (same_ctrl && i == start + 3) ctrl_we = 1'b0;
      @(negedge clk); #1;
    end
  endtask

  task automatic t_reset_hiz();
    chk(pin_oe == '0, "R1", pin_oe, 0);
    wr_ctrl(4'b1000);
    repeat (5) @(negedge clk);
    #1;
    chk(pin_oe == '0, "R1", pin_oe, 0);
    wr_ctrl(4'b0000);
    chk(pin_oe == '0, "R1", pin_oe, 0);
  endtask

  task automatic t_plain_out();
    logic [NP-1:0] pats [4] = '{4'b1010, 4'b0101, 4'b1111, 4'b0000};
    foreach (pats[k]) begin
      wr_data(pats[k]);
      exp_latch = pats[k];
      chk(pin_oe == '1, "R2", pin_oe, 4'hf);
      chk(pin_out == pats[k], "R2", pin_out, pats[k]);
    end
  endtask

  task automatic t_tone_codes();
    wr_data(4'b0000); exp_latch = 4'b0000;
    wr_ctrl(4'b1011);          // code 3, changed from 0
    tone_scan(half_of(3), 0, 4 * half_of(3), 1'b0, '0, 1'b0, '0, "R4 code3");
    wr_ctrl(4'b1000);          // code 0
    tone_scan(half_of(0), 0, 12, 1'b0, '0, 1'b0, '0, "R4 code0");
    wr_ctrl(4'b1111);          // code 7
    tone_scan(half_of(7), 0, 4 * half_of(7), 1'b0, '0, 1'b0, '0, "R4 code7");
  endtask

  task automatic t_latch_hidden();
    wr_ctrl(4'b1001);          // code 1, tone mode
    tone_scan(half_of(1), 0, 16, 1'b1, 4'b1111, 1'b0, '0, "R5 hidden write");
    exp_latch = 4'b1111;
    tone_scan(half_of(1), 16, 12, 1'b0, '0, 1'b1, 4'b1001, "R9 same code");
    wr_ctrl(4'b0001);          // back to output, same code
    chk(pin_out[0] == exp_latch[0], "R5", pin_out[0], exp_latch[0]);
    chk(pin_out == exp_latch, "R3", pin_out, exp_latch);
  endtask

  task automatic t_clock_stop();
    wr_data(4'b0110); exp_latch = 4'b0110;
    wr_ctrl(4'b1000);          // code 0, tone mode
    repeat (3) @(negedge clk);
    clk_stop = 1'b1; #1;
    chk(pin_oe == '0, "R7", pin_oe, 0);
    @(negedge clk); data_we = 1'b1; data_wdata = 4'b1001;
    ctrl_we = 1'b1; ctrl_wdata = 4'b0111;
    @(negedge clk); data_we = 1'b0; ctrl_we = 1'b0; #1;
    chk(pin_oe == '0, "R7", pin_oe, 0);
    @(negedge clk); clk_stop = 1'b0;
    @(negedge clk); #1;
    chk(pin_oe == '1, "R8", pin_oe, 4'hf);
    chk(pin_out[NP-1:1] == exp_latch[NP-1:1], "R7", pin_out[NP-1:1], exp_latch[NP-1:1]);
    tone_scan(half_of(0), 1, 10, 1'b0, '0, 1'b0, '0, "R8 restart");
    wr_ctrl(4'b0000);          // output mode, code unchanged
    chk(pin_out == exp_latch, "R8", pin_out, exp_latch);
  endtask

  initial begin
    while (cycles < 100000) begin
      @(posedge clk);
      cycles++;
    end
    total++; bad++;
    $display("FAIL watchdog: actual=%0d expected=<100000 cycles", cycles);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    t_reset_hiz();
    t_plain_out();
    t_tone_codes();
    t_latch_hidden();
    t_clock_stop();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule